// File: doc/BRIEF.md
# Switchable Encoding-Set Selector

This block keeps a writable identifier pair (a vendor ID and an architecture ID) that chooses which of several mutually exclusive instruction-encoding sets is live. A small fixed table lists the pairs the core supports. The index of the matching entry drives a one-hot enable, one bit per per-extension decoder. Each decoder's match is gated by its enable bit. When a valid instruction word is claimed by no enabled decoder, an illegal-instruction flag is raised.

The block also holds a machine and a supervisor trap-vector base for every supported pair. Both vector outputs always come from the bank of the active pair, so a trap resolves against a consistent pair and vector. A trap never changes the pair. A CSR write that lands in the same cycle as a trap is squashed. After a switch is accepted, the block raises a short stall request so that the pipeline can drop words fetched under the old encoding. A switch enables and disables encodings only. It does not touch any stored vector or other state.

Top module: `isa_set_select`

## Requirements
- R1: After reset the active set is index 0. The ID reads return entry 0 of the table (vendor 0, architecture 0). All vector bases read as zero and `stall` is low.
- R2: `dec_en` has exactly one bit set: bit k, where k is the active index. `dec_hit` equals `dec_match` ANDed with `dec_en`.
- R3: `illegal` is high in a cycle exactly when `dec_valid` is high and `dec_hit` is zero.
- R4: A write to address 0xF11 stages a vendor value. A write to address 0xF12 with data A commits the pair (staged vendor, A) when that pair is in the table. The table is index 0 = (0,0), 1 = (0x5A5,0xEEE1), 2 = (0x5A5,0xEEE2), 3 = (0x5A5,0x0003). Reads of 0xF11 and 0xF12 return the active pair.
- R5: An architecture write that names a pair not in the table leaves the active pair unchanged and raises no stall.
- R6: Machine bases sit at 0x7C0+k and supervisor bases at 0x7C8+k, for pair k. A write stores the data with bits [1:0] cleared, and a read returns the stored value. `mvec` and `svec` always show the entry of the active pair.
- R7: A pair switch leaves every stored vector base unchanged.
- R8: `trap_vec` shows the supervisor base of the active pair when `trap_priv` is 2'b01, and the machine base otherwise.
- R9: A `trap` pulse never changes the active pair. Any CSR write in the same cycle as `trap` is discarded.
- R10: Each accepted pair write holds `stall` high for STALL_CYC (default 2) cycles after the write edge, then lets it fall.
- R11: Unmapped CSR addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_wr | input | 1 | CSR write strobe |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| dec_valid | input | 1 | Instruction word valid in decode |
| dec_match | input | NSETS | Raw match from each decoder |
| dec_en | output | NSETS | One-hot decoder enable |
| dec_hit | output | NSETS | Gated decoder match |
| illegal | output | 1 | No enabled decoder claimed the valid word |
| trap | input | 1 | Trap-entry strobe |
| trap_priv | input | 2 | Target privilege of the trap (01 = supervisor) |
| mvec | output | XLEN | Machine vector base of the active pair |
| svec | output | XLEN | Supervisor vector base of the active pair |
| trap_vec | output | XLEN | Vector base for the trap target privilege |
| stall | output | 1 | Pipeline stall request after a switch |

## Verification
Random sequences mix vendor staging writes, architecture writes drawn both from the table and from junk values, vector writes, reads, and traps with random privilege. A bench model predicts the active pair and banks, so legal commits are told apart from rejected pairs. Random match vectors against the one-hot enable separate a correctly gated hit from a claim by a disabled decoder, and they also exercise the illegal flag. Directed cases cover three situations: a trap in the same cycle as a legal switch, which shows that the write is squashed; a round trip through every set, which shows that the banks survive switching; and unaligned vector data, which shows that the low bits are cleared.

// File: rtl/isa_set_select.sv
module isa_set_select #(
  parameter int NSETS = 4,
  parameter int XLEN = 32,
  parameter int STALL_CYC = 2,
  parameter logic [NSETS*XLEN-1:0] VID_TAB = {32'h5A5, 32'h5A5, 32'h5A5, 32'h0},
  parameter logic [NSETS*XLEN-1:0] AID_TAB = {32'h3, 32'hEEE2, 32'hEEE1, 32'h0},
  parameter logic [11:0] ADR_VID = 12'hF11,
  parameter logic [11:0] ADR_AID = 12'hF12,
  parameter logic [11:0] ADR_MVB = 12'h7C0,
  parameter logic [11:0] ADR_SVB = 12'h7C8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      csr_addr,
  input  logic             csr_wr,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  input  logic             dec_valid,
  input  logic [NSETS-1:0] dec_match,
  output logic [NSETS-1:0] dec_en,
  output logic [NSETS-1:0] dec_hit,
  output logic             illegal,
  input  logic             trap,
  input  logic [1:0]       trap_priv,
  output logic [XLEN-1:0]  mvec,
  output logic [XLEN-1:0]  svec,
  output logic [XLEN-1:0]  trap_vec,
  output logic             stall
);
  localparam int IW = (NSETS > 1) ? $clog2(NSETS) : 1;
  localparam int CW = $clog2(STALL_CYC + 1);
  localparam logic [11:0] MEND = ADR_MVB + 12'(NSETS);
  localparam logic [11:0] SEND = ADR_SVB + 12'(NSETS);

  logic [IW-1:0]   sel_q;
  logic [XLEN-1:0] pvid_q;
  logic [XLEN-1:0] mtab_q [NSETS];
  logic [XLEN-1:0] stab_q [NSETS];
  logic [CW-1:0]   scnt_q;

  logic          lk_hit;
  logic [IW-1:0] lk_idx;
  logic          wr_ok, in_m, in_s, commit;
  logic [IW-1:0] m_idx, s_idx;
  logic [XLEN-1:0] wd_al;

  assign wr_ok  = csr_wr & ~trap;
  assign in_m   = (csr_addr >= ADR_MVB) && (csr_addr < MEND);
  assign in_s   = (csr_addr >= ADR_SVB) && (csr_addr < SEND);
  assign m_idx  = IW'(csr_addr - ADR_MVB);
  assign s_idx  = IW'(csr_addr - ADR_SVB);
  assign wd_al  = {csr_wdata[XLEN-1:2], 2'b00};
  assign commit = wr_ok && (csr_addr == ADR_AID) && lk_hit;

  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = 0; i < NSETS; i++) begin
      if (!lk_hit && VID_TAB[i*XLEN +: XLEN] == pvid_q &&
          AID_TAB[i*XLEN +: XLEN] == csr_wdata) begin
        lk_hit = 1'b1;
        lk_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      pvid_q <= VID_TAB[XLEN-1:0];
      scnt_q <= '0;
      for (int i = 0; i < NSETS; i++) begin
        mtab_q[i] <= '0;
        stab_q[i] <= '0;
      end
    end else begin
      if (wr_ok && csr_addr == ADR_VID) pvid_q <= csr_wdata;
      if (commit) sel_q <= lk_idx;
      if (wr_ok && in_m) mtab_q[m_idx] <= wd_al;
      if (wr_ok && in_s) stab_q[s_idx] <= wd_al;
      if (commit) scnt_q <= CW'(STALL_CYC);
      else if (scnt_q != '0) scnt_q <= scnt_q - 1'b1;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == ADR_VID)      csr_rdata = VID_TAB[sel_q*XLEN +: XLEN];
    else if (csr_addr == ADR_AID) csr_rdata = AID_TAB[sel_q*XLEN +: XLEN];
    else if (in_m)                csr_rdata = mtab_q[m_idx];
    else if (in_s)                csr_rdata = stab_q[s_idx];
  end

  assign dec_en   = NSETS'(1) << sel_q;
  assign dec_hit  = dec_match & dec_en;
  assign illegal  = dec_valid & ~|dec_hit;
  assign mvec     = mtab_q[sel_q];
  assign svec     = stab_q[sel_q];
  assign trap_vec = (trap_priv == 2'b01) ? svec : mvec;
  assign stall    = (scnt_q != '0);

  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dec_en) == 1); // R2
  AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dec_hit) <= 1); // R2
  AST_ILLEGAL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> dec_valid); // R3
  AST_TRAP_HOLDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> $stable(sel_q)); // R9
  AST_SWITCH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> stall); // R10
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mvec[1:0] == 2'b00 && svec[1:0] == 2'b00); // R6
endmodule

// File: tb/isa_set_select_tb.sv
module isa_set_select_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic clk = 0, rst_n = 0;
  logic [11:0] csr_addr = 0;
  logic csr_wr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic dec_valid = 0;
  logic [NS-1:0] dec_match = 0, dec_en, dec_hit;
  logic illegal, trap = 0, stall;
  logic [1:0] trap_priv = 0;
  logic [31:0] mvec, svec, trap_vec;

  int checks = 0, errors = 0;

  logic [31:0] vt [NS] = '{32'h0, 32'h5A5, 32'h5A5, 32'h5A5};
  logic [31:0] at [NS] = '{32'h0, 32'hEEE1, 32'hEEE2, 32'h3};
  int m_sel, m_cnt;
  logic [31:0] m_pv;
  logic [31:0] m_mt [NS];
  logic [31:0] m_st [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_set_select dut_i (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic int find(logic [31:0] v, logic [31:0] a);
    for (int i = 0; i < NS; i++) if (vt[i] == v && at[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] ad);
    if (ad == 12'hF11) return vt[m_sel];
    if (ad == 12'hF12) return at[m_sel];
    if (ad >= 12'h7C0 && ad < 12'h7C4) return m_mt[ad - 12'h7C0];
    if (ad >= 12'h7C8 && ad < 12'h7CC) return m_st[ad - 12'h7C8];
    return 32'h0;
  endfunction

  task automatic model_edge();
    bit acc = 0;
    if (csr_wr && !trap) begin
      if (csr_addr == 12'hF11) m_pv = csr_wdata;
      if (csr_addr == 12'hF12 && find(m_pv, csr_wdata) >= 0) begin
        m_sel = find(m_pv, csr_wdata); acc = 1;
      end
      if (csr_addr >= 12'h7C0 && csr_addr < 12'h7C4) m_mt[csr_addr - 12'h7C0] = csr_wdata & ~32'h3;
      if (csr_addr >= 12'h7C8 && csr_addr < 12'h7CC) m_st[csr_addr - 12'h7C8] = csr_wdata & ~32'h3;
    end
    if (acc) m_cnt = 2; else if (m_cnt > 0) m_cnt--;
  endtask

  task automatic check_outputs();
    logic [NS-1:0] en = NS'(1) << m_sel;
    #1;
    check("R4/R6/R11 rdata", csr_rdata, exp_rd(csr_addr));
    check("R2 dec_en", 32'(dec_en), 32'(en));
    check("R2 dec_hit", 32'(dec_hit), 32'(dec_match & en));
    check("R3 illegal", 32'(illegal), 32'(dec_valid && ((dec_match & en) == 0)));
    check("R6 mvec", mvec, m_mt[m_sel]);
    check("R6 svec", svec, m_st[m_sel]);
    check("R8 trap_vec", trap_vec, (trap_priv == 2'b01) ? m_st[m_sel] : m_mt[m_sel]);
    check("R10 stall", 32'(stall), 32'(m_cnt > 0));
  endtask

  task automatic step(logic [11:0] ad, logic wr, logic [31:0] wd, logic tr);
    csr_addr = ad; csr_wr = wr; csr_wdata = wd; trap = tr;
    trap_priv = 2'($urandom); dec_valid = 1'($urandom); dec_match = NS'($urandom);
    check_outputs();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    csr_wr = 0; trap = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] addrs [6] = '{12'hF11, 12'hF12, 12'h7C1, 12'h7CA, 12'h123, 12'h7C3};
    void'($urandom(32'd4242));
    m_sel = 0; m_cnt = 0; m_pv = 0;
    for (int i = 0; i < NS; i++) begin m_mt[i] = 0; m_st[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    csr_addr = 12'hF11; #1; check("R1 vendor", csr_rdata, 32'h0);
    csr_addr = 12'hF12; #1; check("R1 arch", csr_rdata, 32'h0);
    check("R1 dec_en", 32'(dec_en), 32'h1);
    check("R1 stall", 32'(stall), 32'h0);
    check("R1 mvec", mvec, 32'h0);
    // R6 aligned vector writes for every bank
    for (int k = 0; k < NS; k++) begin
      step(12'h7C0 + 12'(k), 1, 32'h8000_0103 + 32'(k << 8), 0);
      step(12'h7C8 + 12'(k), 1, 32'h4000_0002 + 32'(k << 8), 0);
    end
    step(12'h7C2, 0, 0, 0);
    check("R6 aligned read", csr_rdata, 32'h8000_0300);
    // R4 switch to set 1, R10 stall window
    step(12'hF11, 1, 32'h5A5, 0);
    step(12'hF12, 1, 32'hEEE1, 0);
    check("R4 sel set1", 32'(dec_en), 32'h2);
    check("R10 stall on", 32'(stall), 32'h1);
    step(12'h0, 0, 0, 0);
    step(12'h0, 0, 0, 0);
    check("R10 stall off", 32'(stall), 32'h0);
    // R9 trap in same cycle as legal switch: squashed
    step(12'hF12, 1, 32'hEEE2, 1);
    check("R9 pair kept", 32'(dec_en), 32'h2);
    // R5 unsupported pair
    step(12'hF12, 1, 32'hDEAD, 0);
    check("R5 kept", 32'(dec_en), 32'h2);
    check("R5 no stall", 32'(stall), 32'h0);
    // R7 round trip through every set keeps banks
    for (int k = 0; k < NS; k++) begin
      step(12'hF11, 1, vt[k], 0);
      step(12'hF12, 1, at[k], 0);
      check("R7 mvec bank", mvec, 32'h8000_0100 + 32'(k << 8));
      check("R7 svec bank", svec, 32'h4000_0000 + 32'(k << 8));
    end
    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 8;
      int k = $urandom % NS;
      logic tr = ($urandom % 6) == 0;
      case (op)
        0: step(12'hF11, 1, ($urandom % 4 == 0) ? $urandom : vt[k], tr);
        1, 2: step(12'hF12, 1, ($urandom % 4 == 0) ? $urandom : at[k], tr);
        3: step(12'h7C0 + 12'(k), 1, $urandom, tr);
        4: step(12'h7C8 + 12'(k), 1, $urandom, tr);
        default: step(addrs[$urandom % 6], 0, $urandom, tr);
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule